// File: doc/BRIEF.md
# Programmable Multi-Modulus Enable Divider

This block divides a fast oscillator clock by a programmable integer ratio. It produces two outputs. The first is a measurement-enable pulse that opens a timing window for a downstream time-to-digital converter. The second is a one-cycle marker that closes every output cycle.

The ratio comes from a chain of divide-by-2/3 stages. The lowest stage is always in use. Each higher stage is in use only while its own disable bit is clear and every stage below it is in use. A stage that is out of use is forced idle, not bypassed, so it contributes nothing. The ratio is `2^k` plus the low `k` bits of the program word, where `k` is the number of stages in use. This covers every ratio from 2 upward. A tap select sets the pulse width to a power of two. The pulse always finishes on the marker cycle.

A phase-step request lengthens exactly one output cycle by one oscillator cycle. This shifts the whole pulse train by one oscillator period, so the window can be walked onto either the free-running cycle or the injection-disturbed cycle. The synchronous design is run by a three-state controller:

- **LOAD** is the state after reset. It always goes to RUN and latches the first configuration.
- **RUN** is the normal state. At the end of a cycle it goes to **STRETCH** if a step is pending; otherwise it stays in RUN.
- **STRETCH** is one lengthened cycle. At its end it always goes back to RUN.

Top module: `mmd_enable_divider`

## Requirements
- R1: While `rst_ni` is low, both `en_o` and `cyc_o` are low.
- R2: With `k` stages in use, the output cycle lasts `2^k + (prog_i mod 2^k)` clock cycles. `k` is 1 plus the number of consecutive clear bits of `dis_i` counted upward from bit 0. Bit `j` of `dis_i` governs stage `j+1`. Program bits of stages that are out of use have no effect.
- R3: The shortest cycle is 2 clocks: `dis_i[0]`=1 and `prog_i[0]`=0. Setting `prog_i[0]`=1 gives 3 clocks. With all stages in use and all program bits set, the default 7-stage chain gives 255.
- R4: The enable pulse is one contiguous run of `2^min(tap_i, k-1)` cycles, and its last cycle is the marker cycle.
- R5: `cyc_o` is high for exactly one clock per output cycle, on the last clock of that cycle.
- R6: A change to `prog_i`, `dis_i` or `tap_i` during an output cycle leaves that cycle unchanged. The new values govern the cycle that follows it.
- R7: A rising edge on `step_i` makes the next output cycle one clock longer than the ratio. The pulse width in that cycle is unchanged. Every later cycle returns to the ratio.
- R8: A rising edge on `step_i` is ignored while an earlier step is still pending or its lengthened cycle is running.
- R9: `step_i` is synchronized and edge detected, so holding it high for many cycles gives a single lengthened cycle.
- R10: The nominal setting gives a cycle of 64 clocks and a 2-clock pulse: stages 0 to 5 in use (`dis_i`=6'b100000), `prog_i`=0, `tap_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | NSTAGES | Program bit for each stage (divide by 3 when set) |
| dis_i | input | NSTAGES-1 | Disable bits; bit j forces stage j+1 idle |
| tap_i | input | TAPW | Tap select; pulse width is 2^tap, clamped to 2^(k-1) |
| step_i | input | 1 | Phase-step request, asynchronous, rising-edge sensitive |
| en_o | output | 1 | Measurement-enable pulse |
| cyc_o | output | 1 | One-cycle marker on the last clock of each output cycle |

## Verification
The ratio is tried with random program words, random stage depths and random taps. This includes taps beyond the chain depth, which tells the clamp apart from plain shifting. It is also tried at fixed corners: ratios 2, 3 and 255, the nominal 64, and upper program bits that must be ignored. For each change, the cycle in flight and the cycle after it are measured. This distinguishes latching at the boundary from taking the new value at once. Step requests are tried as a single short pulse, as two pulses closer together than one output cycle, and as a long level. The expected single extra clock separates correct edge detection and blocking from double counting.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_RUN     = 2'd1,
        ST_STRETCH = 2'd2
    } mmd_state_e;

endpackage

// File: rtl/mmd_stage_chain.sv
module mmd_stage_chain #(
    parameter int NSTAGES = 7,
    parameter int RW      = NSTAGES + 1,
    parameter int KW      = $clog2(NSTAGES + 1)
) (
    input  logic [NSTAGES-1:0] prog_i,
    input  logic [NSTAGES-2:0] dis_i,
    output logic [RW-1:0]      ratio_o,
    output logic [KW-1:0]      depth_o
);

    logic [NSTAGES-1:0]        act;
    logic [NSTAGES-1:0]        top;
    logic [NSTAGES:0][RW-1:0]  psum;
    logic [NSTAGES:0][RW-1:0]  tsum;
    logic [NSTAGES:0][KW-1:0]  kcnt;

    assign psum[0] = '0;
    assign tsum[0] = '0;
    assign kcnt[0] = '0;

    for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
        // a stage is live only if every stage below it is live
        if (i == 0) begin : g_first
            assign act[i] = 1'b1;
        end else begin : g_upper
            assign act[i] = act[i-1] & ~dis_i[i-1];
        end

        // the highest live stage supplies the 2^k term
        if (i == NSTAGES - 1) begin : g_last
            assign top[i] = act[i];
        end else begin : g_mid
            assign top[i] = act[i] & (dis_i[i] | ~act[i]);
        end

        assign psum[i+1] = psum[i] + ((act[i] & prog_i[i]) ? (RW'(1) << i) : '0);
        assign tsum[i+1] = tsum[i] + (top[i] ? (RW'(1) << (i + 1)) : '0);
        assign kcnt[i+1] = kcnt[i] + KW'(act[i]);
    end

    assign ratio_o = psum[NSTAGES] + tsum[NSTAGES];
    assign depth_o = kcnt[NSTAGES];

endmodule

// File: rtl/mmd_step_ctl.sv
module mmd_step_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic consume_i,
    input  logic stretch_i,
    output logic pend_o
);

    logic s1_q, s2_q, s3_q;
    logic pend_q;
    logic edge_det;
    logic busy;

    assign edge_det = s2_q & ~s3_q;
    assign busy     = pend_q | stretch_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            s3_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            s1_q <= step_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (consume_i) begin
                pend_q <= 1'b0;
            end else if (edge_det && !busy) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign pend_o = pend_q;

    // R8
    step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && !consume_i) |=> pend_q);

    // R8
    no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q) |-> !$past(stretch_i));

endmodule

// File: rtl/mmd_period_fsm.sv
module mmd_period_fsm
    import mmd_pkg::*;
#(
    parameter int RW   = 8,
    parameter int KW   = 3,
    parameter int TAPW = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [RW-1:0]   ratio_i,
    input  logic [KW-1:0]   depth_i,
    input  logic [TAPW-1:0] tap_i,
    input  logic            pend_i,
    output logic            consume_o,
    output logic            stretch_o,
    output logic            en_o,
    output logic            cyc_o
);

    mmd_state_e     state_q, state_nx;
    logic [RW-1:0]  cnt_q, cnt_nx;
    logic [RW-1:0]  w_q, w_nx;
    logic [KW-1:0]  tap_eff;
    logic           load;
    logic           last;

    assign last    = (cnt_q == '0);
    assign tap_eff = (KW'(tap_i) > (depth_i - KW'(1))) ? (depth_i - KW'(1)) : KW'(tap_i);
    assign w_nx    = RW'(1) << tap_eff;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            w_q     <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            if (load) begin
                w_q <= w_nx;
            end
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q - RW'(1);
        load     = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                state_nx = ST_RUN;
                cnt_nx   = ratio_i - RW'(1);
                load     = 1'b1;
            end
            ST_RUN: begin
                if (last) begin
                    load = 1'b1;
                    if (pend_i) begin
                        state_nx = ST_STRETCH;
                        cnt_nx   = ratio_i;
                    end else begin
                        cnt_nx   = ratio_i - RW'(1);
                    end
                end
            end
            ST_STRETCH: begin
                if (last) begin
                    load     = 1'b1;
                    state_nx = ST_RUN;
                    cnt_nx   = ratio_i - RW'(1);
                end
            end
            default: begin
                state_nx = ST_LOAD;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        en_o      = (state_q != ST_LOAD) && (cnt_q < w_q);
        cyc_o     = (state_q != ST_LOAD) && last;
        consume_o = (state_q == ST_RUN) && last && pend_i;
        stretch_o = (state_q == ST_STRETCH);
    end

    // R7
    stretch_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STRETCH && last) |=> (state_q == ST_RUN));

    // R5
    marker_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o |=> !cyc_o);

    // R4
    en_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o |-> en_o);

    // R6
    count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_LOAD && !last) |=> (cnt_q == $past(cnt_q) - RW'(1)));

endmodule

// File: rtl/mmd_enable_divider.sv
module mmd_enable_divider #(
    parameter int NSTAGES = 7,
    parameter int TAPW    = $clog2(NSTAGES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NSTAGES-1:0] prog_i,
    input  logic [NSTAGES-2:0] dis_i,
    input  logic [TAPW-1:0]    tap_i,
    input  logic               step_i,
    output logic               en_o,
    output logic               cyc_o
);

    localparam int RW = NSTAGES + 1;
    localparam int KW = $clog2(NSTAGES + 1);

    logic [RW-1:0] ratio;
    logic [KW-1:0] depth;
    logic          pend;
    logic          consume;
    logic          stretch;

    mmd_stage_chain #(
        .NSTAGES (NSTAGES),
        .RW      (RW),
        .KW      (KW)
    ) u_chain (
        .prog_i  (prog_i),
        .dis_i   (dis_i),
        .ratio_o (ratio),
        .depth_o (depth)
    );

    mmd_step_ctl u_step (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step_i),
        .consume_i (consume),
        .stretch_i (stretch),
        .pend_o    (pend)
    );

    mmd_period_fsm #(
        .RW   (RW),
        .KW   (KW),
        .TAPW (TAPW)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ratio_i   (ratio),
        .depth_i   (depth),
        .tap_i     (tap_i),
        .pend_i    (pend),
        .consume_o (consume),
        .stretch_o (stretch),
        .en_o      (en_o),
        .cyc_o     (cyc_o)
    );

endmodule

// File: tb/mmd_enable_divider_bench.sv
`timescale 1ns/1ps
module mmd_enable_divider_bench;

    localparam int N    = 7;
    localparam int TAPW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    prog = '0;
    logic [N-2:0]    dis = '0;
    logic [TAPW-1:0] tap = '0;
    logic            step = 1'b0;
    logic            en, cyc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int per_log [0:2047];
    int wid_log [0:2047];
    int tot_log [0:2047];
    int nper = 0;
    int ccount = 0, run = 0, tot = 0, dbl = 0;
    logic prev_cyc = 1'b0;
    int cur_r, cur_w;

    always #4 clk = ~clk;

    mmd_enable_divider #(.NSTAGES(N)) u_mmd_enable_divider (
        .clk_i (clk), .rst_ni (rst_n), .prog_i (prog), .dis_i (dis),
        .tap_i (tap), .step_i (step), .en_o (en), .cyc_o (cyc)
    );

    // period monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            ccount++;
            if (en) begin run++; tot++; end else run = 0;
            if (cyc && prev_cyc) dbl++;
            prev_cyc = cyc;
            if (cyc && nper < 2048) begin
                per_log[nper] = ccount;
                wid_log[nper] = run;
                tot_log[nper] = tot;
                nper++;
                ccount = 0;
                tot = 0;
            end
        end
    end

    function automatic int depth_of(logic [N-2:0] d);
        int k = 1;
        for (int i = 0; i < N - 1; i++) if (!d[i] && k == i + 1) k++;
        return k;
    endfunction

    function automatic int ratio_of(logic [N-1:0] p, logic [N-2:0] d);
        int k = depth_of(d);
        return (1 << k) + (int'(p) & ((1 << k) - 1));
    endfunction

    function automatic int width_of(logic [TAPW-1:0] t, logic [N-2:0] d);
        int k = depth_of(d);
        int e = (int'(t) > k - 1) ? k - 1 : int'(t);
        return 1 << e;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_per(int n);
        int target = nper + n;
        while (nper < target) @(posedge clk);
        #1;
    endtask

    task automatic wait_idx(int idx);
        while (nper <= idx) @(posedge clk);
        #1;
    endtask

    task automatic apply_cfg(logic [N-1:0] p, logic [N-2:0] d, logic [TAPW-1:0] t, string req);
        int base, nr, nw;
        wait_per(1);
        base = nper;
        prog = p; dis = d; tap = t;
        nr = ratio_of(p, d);
        nw = width_of(t, d);
        wait_idx(base + 1);
        // R6: the cycle in flight keeps the old ratio
        chk(per_log[base] == cur_r, "R6", per_log[base], cur_r);
        chk(per_log[base + 1] == nr, req, per_log[base + 1], nr);
        // R4: contiguous pulse ending on the marker
        chk(wid_log[base + 1] == nw && tot_log[base + 1] == nw, "R4",
            tot_log[base + 1], nw);
        cur_r = nr;
        cur_w = nw;
    endtask

    task automatic step_pattern(int kind);
        int base;
        wait_per(1);
        base = nper;
        if (kind == 0) begin
            step = 1'b1; repeat (3) @(posedge clk); #1; step = 1'b0;
        end else if (kind == 1) begin
            step = 1'b1; repeat (3) @(posedge clk); #1; step = 1'b0;
            repeat (3) @(posedge clk); #1; step = 1'b1;
            repeat (3) @(posedge clk); #1; step = 1'b0;
        end else begin
            step = 1'b1;
        end
        wait_idx(base + 4);
        step = 1'b0;
        chk(per_log[base] == cur_r, kind == 0 ? "R7" : (kind == 1 ? "R8" : "R9"),
            per_log[base], cur_r);
        chk(per_log[base + 1] == cur_r + 1, kind == 0 ? "R7" : (kind == 1 ? "R8" : "R9"),
            per_log[base + 1], cur_r + 1);
        chk(per_log[base + 2] == cur_r && per_log[base + 3] == cur_r && per_log[base + 4] == cur_r,
            kind == 0 ? "R7" : (kind == 1 ? "R8" : "R9"), per_log[base + 2], cur_r);
        // R7: width unaffected in the lengthened cycle
        chk(tot_log[base + 1] == cur_w, "R7", tot_log[base + 1], cur_w);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        prog = '0; dis = 6'b100000; tap = 3'd1;
        repeat (5) @(negedge clk);
        // R1
        chk(en == 1'b0 && cyc == 1'b0, "R1", {en, cyc}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        cur_r = 64; cur_w = 2;
        wait_per(2);
        // R10: nominal setting
        chk(per_log[nper - 1] == 64, "R10", per_log[nper - 1], 64);
        chk(tot_log[nper - 1] == 2, "R10", tot_log[nper - 1], 2);

        apply_cfg(7'h00, 6'b000001, 3'd3, "R3");
        apply_cfg(7'h01, 6'b000001, 3'd0, "R3");
        apply_cfg(7'h7F, 6'b000000, 3'd2, "R3");
        apply_cfg(7'h00, 6'b000010, 3'd1, "R2");
        apply_cfg(7'h7C, 6'b000010, 3'd1, "R2");
        apply_cfg(7'h00, 6'b100000, 3'd1, "R10");

        step_pattern(0);
        step_pattern(1);
        step_pattern(2);
        step_pattern(0);

        for (int it = 0; it < 24; it++) begin
            int k = 1 + ($urandom % N);
            logic [N-2:0] d = 6'($urandom);
            for (int i = 0; i < N - 1; i++) begin
                if (i < k - 1) d[i] = 1'b0;
                else if (i == k - 1) d[i] = 1'b1;
            end
            apply_cfg(7'($urandom), d, 3'($urandom), "R2");
        end

        // R5: marker never held for two clocks
        chk(dbl == 0, "R5", dbl, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule